// File: doc/BRIEF.md
# Group-Scoped Address Translation Cache

This block is a small fully associative translation cache. Each entry stores a virtual page number, a physical page number, a permission field and a 16-bit address-space tag. The tag has two parts: the upper 6 bits name a group, and the lower 10 bits name a process within that group. There is no separate global flag. An entry whose lower 10 tag bits are zero is shared by every process in the same group, and it is never shared with processes in other groups.

A lookup presents a virtual page number and the current 16-bit tag. Hit, physical page and permissions come back in the same cycle. A fill writes one entry through a round-robin victim pointer. The write is registered. A flush either clears every entry, or clears only the entries whose full tag equals a given value. Process tags are handed out modulo 1024. Before a tag is reused for a new process, software issues a tag flush.

Top module: `asidgrp_tlb`

## Requirements
- R1: After reset no lookup hits, and the first fill is written to slot 0.
- R2: An entry whose lower 10 tag bits are non-zero hits only when its full 16-bit tag equals the lookup tag.
- R3: An entry whose lower 10 tag bits are all zero hits for any lookup tag whose upper 6 bits equal the entry's upper 6 bits.
- R4: A group-shared entry never hits for a lookup tag whose upper 6 bits differ from its own.
- R5: A hit needs a valid entry with an equal virtual page number. On a hit the outputs carry that entry's physical page and permissions. On a miss both outputs are zero.
- R6: A fill is not visible to a lookup in its own cycle. It is visible from the next cycle on.
- R7: Fills go to slots 0, 1, 2 and so on in turn. After the last slot the pointer wraps to 0 and overwrites the oldest entries.
- R8: When several entries hit, the outputs come from the lowest-numbered one.
- R9: A tag flush invalidates, in one cycle, every entry whose full 16-bit tag equals the given value. Entries with any other tag are kept, including the group-shared entry of the same group when the given low bits are non-zero.
- R10: A flush-all invalidates every entry in one cycle.
- R11: A lookup in the same cycle as a flush sees the contents from before the flush.
- R12: When a fill and a flush fall in the same cycle, the flush acts on the old contents and the new entry survives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | 16 | Current address-space tag for the lookup |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Physical page of the hit entry, zero on a miss |
| lk_perm | output | PERM_W | Permissions of the hit entry, zero on a miss |
| fill_en | input | 1 | Write one entry at the round-robin slot |
| fill_vpn | input | VPN_W | Virtual page to write |
| fill_asid | input | 16 | Tag to write |
| fill_ppn | input | PPN_W | Physical page to write |
| fill_perm | input | PERM_W | Permissions to write |
| flush_all | input | 1 | Invalidate all entries |
| flush_asid_en | input | 1 | Invalidate entries whose tag equals flush_asid |
| flush_asid | input | 16 | Tag to invalidate |

## Verification
The collisions of interest are a lookup in the same cycle as a flush, and a fill in the same cycle as a flush. Both are driven on purpose in directed steps. They also arise often in a long random phase that mixes fills, tag flushes and flush-alls over a small page and tag space, so that duplicates and group-shared entries collide. For the lookup case, the output in the flush cycle must still show the old entry, and the next cycle must show the miss. For the fill case, the entry written in that cycle must hit afterwards while everything else flushed is gone. A behavioural reference model in the bench judges every cycle.

// File: rtl/tlb_asid_pkg.sv
package tlb_asid_pkg;
  localparam int ASID_W = 16;
  localparam int GRP_W  = 6;
  localparam int ID_W   = ASID_W - GRP_W;

  typedef logic [ASID_W-1:0] asid_t;

  // a zero process field marks an entry shared inside its group
  function automatic logic asid_is_shared(asid_t a);
    return a[ID_W-1:0] == '0;
  endfunction

  function automatic logic asid_same_group(asid_t a, asid_t b);
    return a[ASID_W-1:ID_W] == b[ASID_W-1:ID_W];
  endfunction

  // does a stored tag admit the current lookup tag
  function automatic logic asid_admits(asid_t ent, asid_t cur);
    if (asid_is_shared(ent)) return asid_same_group(ent, cur);
    return ent == cur;
  endfunction
endpackage

// File: rtl/tlb_match_cell.sv
module tlb_match_cell
  import tlb_asid_pkg::*;
#(
  parameter int VPN_W = 20
) (
  input  logic             vld,
  input  logic [VPN_W-1:0] ent_vpn,
  input  asid_t            ent_asid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  asid_t            lk_asid,
  input  asid_t            flush_asid,
  output logic             lk_match,
  output logic             flush_match
);
  logic vpn_eq;
  logic tag_ok;

  assign vpn_eq      = ent_vpn == lk_vpn;
  assign tag_ok      = asid_admits(ent_asid, lk_asid);
  assign lk_match    = vld && vpn_eq && tag_ok;
  assign flush_match = vld && (ent_asid == flush_asid);
endmodule

// File: rtl/tlb_prio_pick.sv
module tlb_prio_pick #(
  parameter int N = 16
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt_oh,
  output logic         any
);
  always_comb begin
    logic found;
    found  = 1'b0;
    gnt_oh = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !found) begin
        gnt_oh[i] = 1'b1;
        found     = 1'b1;
      end
    end
    any = found;
  end
endmodule

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_asid_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           fill_en,
  input  logic [VPN_W-1:0]               fill_vpn,
  input  asid_t                          fill_asid,
  input  logic [PPN_W-1:0]               fill_ppn,
  input  logic [PERM_W-1:0]              fill_perm,
  input  logic                           flush_all,
  input  logic                           flush_asid_en,
  input  logic [ENTRIES-1:0]             flush_match,
  output logic [ENTRIES-1:0]             vld_q,
  output logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn,
  output logic [ENTRIES-1:0][ASID_W-1:0] ent_asid,
  output logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn,
  output logic [ENTRIES-1:0][PERM_W-1:0] ent_perm,
  output logic [IDX_W-1:0]               fill_slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic [ENTRIES-1:0] kill_vec;
  logic [ENTRIES-1:0] vld_d;

  function automatic logic [IDX_W-1:0] rr_next(logic [IDX_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  // flush acts on old contents, the fill is applied on top of it
  always_comb begin
    if (flush_all)          kill_vec = '1;
    else if (flush_asid_en) kill_vec = flush_match;
    else                    kill_vec = '0;
    vld_d = vld_q & ~kill_vec;
    if (fill_en) vld_d[fill_slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q     <= '0;
      fill_slot <= '0;
    end else begin
      vld_q <= vld_d;
      if (fill_en) fill_slot <= rr_next(fill_slot);
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      ent_vpn[fill_slot]  <= fill_vpn;
      ent_asid[fill_slot] <= fill_asid;
      ent_ppn[fill_slot]  <= fill_ppn;
      ent_perm[fill_slot] <= fill_perm;
    end
  end
endmodule

// File: rtl/asidgrp_tlb.sv
module asidgrp_tlb
  import tlb_asid_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [15:0]       lk_asid,
  output logic              lk_hit,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  input  logic              fill_en,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [15:0]       fill_asid,
  input  logic [PPN_W-1:0]  fill_ppn,
  input  logic [PERM_W-1:0] fill_perm,
  input  logic              flush_all,
  input  logic              flush_asid_en,
  input  logic [15:0]       flush_asid
);
  localparam int IDX_W = $clog2(ENTRIES);

  logic [ENTRIES-1:0]             vld_q;
  logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
  logic [ENTRIES-1:0][ASID_W-1:0] ent_asid;
  logic [ENTRIES-1:0][PPN_W-1:0]  ent_ppn;
  logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;
  logic [IDX_W-1:0]               fill_slot;
  logic [ENTRIES-1:0]             match_vec;
  logic [ENTRIES-1:0]             flush_vec;
  logic [ENTRIES-1:0]             sel_oh;
  logic                           any_hit;

  tlb_store #(
    .ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W), .PERM_W(PERM_W)
  ) u_store (
    .clk(clk), .rst_n(rst_n),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm),
    .flush_all(flush_all), .flush_asid_en(flush_asid_en),
    .flush_match(flush_vec),
    .vld_q(vld_q), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .ent_ppn(ent_ppn), .ent_perm(ent_perm), .fill_slot(fill_slot)
  );

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cell
    tlb_match_cell #(.VPN_W(VPN_W)) u_cell (
      .vld(vld_q[g]), .ent_vpn(ent_vpn[g]), .ent_asid(ent_asid[g]),
      .lk_vpn(lk_vpn), .lk_asid(lk_asid), .flush_asid(flush_asid),
      .lk_match(match_vec[g]), .flush_match(flush_vec[g])
    );
  end

  tlb_prio_pick #(.N(ENTRIES)) u_pick (
    .req(match_vec), .gnt_oh(sel_oh), .any(any_hit)
  );

  always_comb begin
    lk_ppn  = '0;
    lk_perm = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (sel_oh[i]) begin
        lk_ppn  = lk_ppn  | ent_ppn[i];
        lk_perm = lk_perm | ent_perm[i];
      end
    end
  end

  assign lk_hit = any_hit;
endmodule

// File: rtl/asidgrp_tlb_chk.sv
module asidgrp_tlb_chk #(
  parameter int ENTRIES = 16,
  parameter int PPN_W   = 20,
  parameter int PERM_W  = 4,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               fill_en,
  input logic               flush_all,
  input logic               flush_asid_en,
  input logic               lk_hit,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic [PERM_W-1:0]  lk_perm,
  input logic [ENTRIES-1:0] vld_q,
  input logic [ENTRIES-1:0] sel_oh,
  input logic [IDX_W-1:0]   fill_slot
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  logic             was_fill;
  logic [IDX_W-1:0] was_slot;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      was_fill <= 1'b0;
      was_slot <= '0;
    end else begin
      was_fill <= fill_en;
      was_slot <= fill_slot;
    end
  end

  p_miss_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_ppn == '0 && lk_perm == '0));

  p_sel_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_oh & ~vld_q) == '0);

  p_one_winner_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_oh));

  p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    was_fill |-> vld_q[was_slot]);

  p_rr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (($past(fill_slot) == LAST) ? (fill_slot == '0)
                                           : (fill_slot == $past(fill_slot) + 1'b1)));

  p_rr_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $stable(fill_slot));

  p_flush_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && !fill_en) |=> (vld_q == '0));

  p_flush_fill_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_all && fill_en) |=> ($countones(vld_q) == 1));

  p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fill_en && !flush_all && !flush_asid_en) |=> $stable(vld_q));
endmodule

bind asidgrp_tlb asidgrp_tlb_chk #(
  .ENTRIES(ENTRIES), .PPN_W(PPN_W), .PERM_W(PERM_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_en(fill_en), .flush_all(flush_all),
  .flush_asid_en(flush_asid_en), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
  .lk_perm(lk_perm), .vld_q(vld_q), .sel_oh(sel_oh), .fill_slot(fill_slot)
);

// File: tb/sim_asidgrp_tlb.sv
`timescale 1ns/1ps
module sim_asidgrp_tlb;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] lk_vpn = '0;
  logic [15:0] lk_asid = '0;
  logic        lk_hit;
  logic [19:0] lk_ppn;
  logic [3:0]  lk_perm;
  logic        fill_en = 1'b0;
  logic [19:0] fill_vpn = '0;
  logic [15:0] fill_asid = '0;
  logic [19:0] fill_ppn = '0;
  logic [3:0]  fill_perm = '0;
  logic        flush_all = 1'b0;
  logic        flush_asid_en = 1'b0;
  logic [15:0] flush_asid = '0;

  always #10 clk = ~clk;

  asidgrp_tlb u0 (
    .clk(clk), .rst_n(rst_n), .lk_vpn(lk_vpn), .lk_asid(lk_asid),
    .lk_hit(lk_hit), .lk_ppn(lk_ppn), .lk_perm(lk_perm),
    .fill_en(fill_en), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_perm(fill_perm), .flush_all(flush_all),
    .flush_asid_en(flush_asid_en), .flush_asid(flush_asid)
  );

  // behavioural reference
  bit          m_v[N];
  logic [19:0] m_vpn[N];
  logic [15:0] m_tag[N];
  logic [19:0] m_ppn[N];
  logic [3:0]  m_perm[N];
  int          m_ptr = 0;

  int    n_run = 0, n_fail = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  function automatic bit tag_ok(logic [15:0] e, logic [15:0] c);
    if (e % 1024 == 0) return (e / 1024) == (c / 1024);
    return e == c;
  endfunction

  task automatic model_lookup(output bit h, output logic [19:0] p, output logic [3:0] q);
    h = 0; p = '0; q = '0;
    for (int i = N - 1; i >= 0; i--)
      if (m_v[i] && m_vpn[i] == lk_vpn && tag_ok(m_tag[i], lk_asid)) begin
        h = 1; p = m_ppn[i]; q = m_perm[i];
      end
  endtask

  task automatic report(string req, bit h, logic [19:0] p, logic [3:0] q,
                        bit eh, logic [19:0] ep, logic [3:0] eq);
    n_run++;
    if (h !== eh || p !== ep || q !== eq) begin
      n_fail++;
      $display("FAIL %s t=%0t actual hit=%0b ppn=%h perm=%h expected hit=%0b ppn=%h perm=%h",
               req, $time, h, p, q, eh, ep, eq);
    end
  endtask

  // one clock: compare against the model, then advance the model at the edge
  task automatic tick();
    bit eh; logic [19:0] ep; logic [3:0] eq;
    #1;
    model_lookup(eh, ep, eq);
    report(cur_req, lk_hit, lk_ppn, lk_perm, eh, ep, eq);
    @(posedge clk);
    if (rst_n) begin
      if (flush_all) begin
        for (int i = 0; i < N; i++) m_v[i] = 0;
      end else if (flush_asid_en) begin
        for (int i = 0; i < N; i++) if (m_tag[i] == flush_asid) m_v[i] = 0;
      end
      if (fill_en) begin
        m_v[m_ptr] = 1; m_vpn[m_ptr] = fill_vpn; m_tag[m_ptr] = fill_asid;
        m_ppn[m_ptr] = fill_ppn; m_perm[m_ptr] = fill_perm;
        m_ptr = (m_ptr + 1) % N;
      end
    end
    @(negedge clk);
    fill_en = 0; flush_all = 0; flush_asid_en = 0;
  endtask

  // directed expectation for the current cycle, call before tick
  task automatic expect_lk(string req, bit eh, logic [19:0] ep, logic [3:0] eq);
    #1;
    report(req, lk_hit, lk_ppn, lk_perm, eh, ep, eq);
  endtask

  task automatic look(logic [19:0] v, logic [5:0] g, logic [9:0] id);
    lk_vpn = v; lk_asid = {g, id};
  endtask

  task automatic fill(logic [19:0] v, logic [5:0] g, logic [9:0] id,
                      logic [19:0] p, logic [3:0] q);
    fill_en = 1; fill_vpn = v; fill_asid = {g, id}; fill_ppn = p; fill_perm = q;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    // R1: empty after reset
    cur_req = "R1";
    look(20'h100, 6'd3, 10'd5);
    expect_lk("R1", 0, '0, '0);
    // R6: fill not visible in its own cycle; lands in slot 0 (R1)
    cur_req = "R6";
    fill(20'h100, 6'd3, 10'd5, 20'h000A1, 4'h3);
    expect_lk("R6", 0, '0, '0);
    tick();
    expect_lk("R6", 1, 20'h000A1, 4'h3);
    tick();
    // R2: private entry needs the full tag
    cur_req = "R2";
    look(20'h100, 6'd3, 10'd6); expect_lk("R2", 0, '0, '0); tick();
    look(20'h100, 6'd4, 10'd5); expect_lk("R2", 0, '0, '0); tick();
    // R3: group-shared entry (slot 1)
    cur_req = "R3";
    fill(20'h200, 6'd3, 10'd0, 20'h000B2, 4'h5); tick();
    look(20'h200, 6'd3, 10'd77); expect_lk("R3", 1, 20'h000B2, 4'h5); tick();
    look(20'h200, 6'd3, 10'd0);  expect_lk("R3", 1, 20'h000B2, 4'h5); tick();
    // R4: not shared across groups
    cur_req = "R4";
    look(20'h200, 6'd5, 10'd77); expect_lk("R4", 0, '0, '0); tick();
    look(20'h200, 6'd5, 10'd0);  expect_lk("R4", 0, '0, '0); tick();
    // R5: page must match
    cur_req = "R5";
    look(20'h201, 6'd3, 10'd77); expect_lk("R5", 0, '0, '0); tick();
    // R9 and R11: tag flush, lookup in flush cycle sees old contents
    cur_req = "R9";
    fill(20'h300, 6'd3, 10'd5, 20'h000C3, 4'h1); tick();
    look(20'h100, 6'd3, 10'd5);
    flush_asid_en = 1; flush_asid = {6'd3, 10'd5};
    expect_lk("R11", 1, 20'h000A1, 4'h3);
    tick();
    expect_lk("R9", 0, '0, '0); tick();
    look(20'h300, 6'd3, 10'd5); expect_lk("R9", 0, '0, '0); tick();
    look(20'h200, 6'd3, 10'd5); expect_lk("R9", 1, 20'h000B2, 4'h5); tick();
    flush_asid_en = 1; flush_asid = {6'd3, 10'd0}; tick();
    expect_lk("R9", 0, '0, '0); tick();
    // R8: lowest slot wins (slots 3..6)
    cur_req = "R8";
    fill(20'h400, 6'd7, 10'd1, 20'h000D1, 4'h2); tick();
    fill(20'h400, 6'd7, 10'd1, 20'h000D2, 4'h4); tick();
    look(20'h400, 6'd7, 10'd1); expect_lk("R8", 1, 20'h000D1, 4'h2); tick();
    fill(20'h500, 6'd7, 10'd0, 20'h000E0, 4'h6); tick();
    fill(20'h500, 6'd7, 10'd9, 20'h000E9, 4'h7); tick();
    look(20'h500, 6'd7, 10'd9); expect_lk("R8", 1, 20'h000E0, 4'h6); tick();
    // R7: sixteen more fills overwrite every slot
    cur_req = "R7";
    for (int k = 0; k < N; k++) begin
      fill(20'h600 + 20'(k), 6'd1, 10'd1, 20'(k + 16), 4'h8); tick();
    end
    look(20'h400, 6'd7, 10'd1); expect_lk("R7", 0, '0, '0); tick();
    look(20'h600, 6'd1, 10'd1); expect_lk("R7", 1, 20'h00010, 4'h8); tick();
    // R12: fill and flush-all together
    cur_req = "R12";
    fill(20'h700, 6'd2, 10'd2, 20'h000FF, 4'h9); flush_all = 1; tick();
    look(20'h700, 6'd2, 10'd2); expect_lk("R12", 1, 20'h000FF, 4'h9); tick();
    look(20'h601, 6'd1, 10'd1); expect_lk("R12", 0, '0, '0); tick();
    // R10: flush-all alone
    cur_req = "R10";
    flush_all = 1; tick();
    look(20'h700, 6'd2, 10'd2); expect_lk("R10", 0, '0, '0); tick();
    // mixed random traffic against the model
    cur_req = "R2/R3/R8/R9/R12 random";
    for (int c = 0; c < 3000; c++) begin
      int r;
      r = $urandom % 16;
      look(20'($urandom % 6), 6'($urandom % 3), 10'($urandom % 3));
      if (r < 7) fill(20'($urandom % 6), 6'($urandom % 3), 10'($urandom % 3),
                      20'($urandom), 4'($urandom));
      if (r == 7 || r == 8 || r == 9) begin
        flush_asid_en = 1; flush_asid = {6'($urandom % 3), 10'($urandom % 3)};
      end
      if (r == 10) flush_all = 1;
      tick();
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule